// File: doc/BRIEF.md
# Two-Vector Scan Chain with Holding Stage

This block is a scan chain of `N` cells. Each cell feeds the logic under test through a holding stage, so the chain can carry one vector while the holding stage drives another. A delay test uses it in four steps. The initialization vector is shifted in and parked in the holding stage. The test vector is then shifted in while the logic still sees the initialization vector. The launch control opens the holding stage, and that one event sends every transition into the logic. A capture strobe later loads the response back into the chain, and the response is shifted out serially.

The holding stage is transparent while either the park or the launch control is high, and it keeps its stored value while both are low. If launch is held high in functional mode, the logic sees the cells directly and the chain acts as a row of ordinary flip-flops.

Top module: `escan_launch_chain`

## Requirements
- R1: While reset is low and on the first cycle after it, all cells and the holding stage read zero, so `drive_out` and `scan_out` are 0.
- R2: When `scan_en` is high at a rising edge, the chain shifts one place toward cell N-1. `scan_in` enters cell 0, and `scan_out` always shows cell N-1. A vector shifted in most-significant bit first therefore lands with bit i in cell i.
- R3: When `park` and `launch` are low in a cycle and were also low in the cycle before, `drive_out` does not change, whatever shifting or capture takes place.
- R4: While `park` or `launch` is high, `drive_out` equals the current content of the chain (transparent).
- R5: At every rising edge where `park` or `launch` is high, the holding stage stores the chain content present just before that edge. Once both controls go low, `drive_out` shows that stored value.
- R6: When `capture` is high and `scan_en` is low at a rising edge, the chain loads `resp_in`. The captured word then leaves on `scan_out` with cell N-1 first and cell 0 last.
- R7: When `scan_en` and `capture` are both high, shifting takes priority and `resp_in` is ignored.
- R8: When a shift and a park fall on the same edge, the holding stage keeps the pre-shift chain content.
- R9: In a two-vector sequence (park V1, shift V2, launch), `drive_out` is V1 for the whole second shift. It becomes V2 only in the launch cycle, and the word captured afterwards is the logic's response to V2.
- R10: With `launch` and `capture` held high and `scan_en` low, `drive_out` follows the cells. The cells take the logic response on each edge, as ordinary flip-flops would.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| scan_en | input | 1 | Shift the chain one place |
| scan_in | input | 1 | Serial data into cell 0 |
| capture | input | 1 | Load `resp_in` into the chain when not shifting |
| park | input | 1 | Open the holding stage to store the first vector |
| launch | input | 1 | Open the holding stage to launch the second vector |
| resp_in | input | N | Response from the logic under test |
| scan_out | output | 1 | Serial data from cell N-1 |
| drive_out | output | N | Vector driven into the logic under test |

## Verification
Two pairs of functions can fall on the same edge. A park can coincide with a shift, and a capture can coincide with a shift. The bench applies each pair on purpose. For the first pair it checks that the holding stage kept the pre-shift word. For the second it checks that the chain shifted and dropped `resp_in`. Every cycle is also compared against a behavioural model of the chain and the holding stage, which covers the launch cycle, in which `drive_out` must move from V1 to V2 with no earlier change.

// File: rtl/escan_launch_chain.sv
module escan_launch_chain #(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         scan_en,
  input  logic         scan_in,
  input  logic         capture,
  input  logic         park,
  input  logic         launch,
  input  logic [N-1:0] resp_in,
  output logic         scan_out,
  output logic [N-1:0] drive_out
);

  logic [N-1:0] chain;
  logic [N-1:0] hold;
  logic         open_w;

  assign open_w = park | launch;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      chain <= '0;
      hold  <= '0;
    end else begin
      if (scan_en)      chain <= {chain[N-2:0], scan_in};
      else if (capture) chain <= resp_in;
      if (open_w)       hold  <= chain;
    end
  end

  assign scan_out  = chain[N-1];
  assign drive_out = open_w ? chain : hold;

  p_shift_r2: assert property (@(posedge clk) disable iff (!rst_n)
    scan_en |=> (chain[0] == $past(scan_in)) && (chain[N-1:1] == $past(chain[N-2:0])));

  p_stable_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!park && !launch && $past(!park && !launch)) |-> $stable(drive_out));

  p_store_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (park || launch) |=> (park || launch || drive_out == $past(chain)));

  p_capture_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (capture && !scan_en) |=> chain == $past(resp_in));

  p_prio_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (capture && scan_en) |=> chain[0] == $past(scan_in));

endmodule

// File: tb/escan_launch_chain_test.sv
module escan_launch_chain_test;
  localparam int N = 8;

  logic clk = 1'b0;
  logic rst_n, scan_en, scan_in, capture, park, launch;
  logic [N-1:0] resp_in, drive_out;
  logic scan_out;

  always #5 clk = ~clk;

  escan_launch_chain #(.N(N)) uut (
    .clk(clk), .rst_n(rst_n), .scan_en(scan_en), .scan_in(scan_in),
    .capture(capture), .park(park), .launch(launch), .resp_in(resp_in),
    .scan_out(scan_out), .drive_out(drive_out));

  function automatic logic [N-1:0] f(logic [N-1:0] x);
    return {x[N-2:0], x[N-1]} ^ x;
  endfunction

  assign resp_in = f(drive_out);

  int nchk = 0, nfail = 0;
  logic [N-1:0] m_chain = '0, m_hold = '0;
  logic [N-1:0] m_drive;

  task automatic chk(string tag, logic [N-1:0] act, logic [N-1:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic cyc(string tag, logic se, logic si, logic cp, logic pk, logic ln);
    logic [N-1:0] nc;
    scan_en = se; scan_in = si; capture = cp; park = pk; launch = ln;
    #1;
    m_drive = (pk | ln) ? m_chain : m_hold;
    chk({tag, " drive_out"}, drive_out, m_drive);
    chk({tag, " scan_out"}, {{(N-1){1'b0}}, scan_out}, {{(N-1){1'b0}}, m_chain[N-1]});
    nc = se ? {m_chain[N-2:0], si} : (cp ? f(m_drive) : m_chain);
    if (pk | ln) m_hold = m_chain;
    m_chain = nc;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic shift_word(string tag, logic [N-1:0] v, logic pk_first);
    for (int i = N - 1; i >= 0; i--)
      cyc(tag, 1'b1, v[i], 1'b0, (i == N - 1) ? pk_first : 1'b0, 1'b0);
  endtask

  localparam logic [N-1:0] V1 = 8'hA5;
  localparam logic [N-1:0] V2 = 8'h3C;

  initial begin
    #1000000;
    nfail++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    logic [N-1:0] got;
    rst_n = 1'b0; scan_en = 0; scan_in = 0; capture = 0; park = 0; launch = 0;
    repeat (3) @(negedge clk);
    chk("R1 drive_out in reset", drive_out, '0);
    chk("R1 scan_out in reset", {{(N-1){1'b0}}, scan_out}, '0);
    rst_n = 1'b1;
    cyc("R1", 0, 0, 0, 0, 0);

    shift_word("R2 shift V1", V1, 1'b0);
    cyc("R5 park V1", 0, 0, 0, 1, 0);
    cyc("R5 closed", 0, 0, 0, 0, 0);
    chk("R5 parked value", drive_out, V1);

    for (int i = N - 1; i >= 0; i--) begin
      cyc("R3 shift V2", 1, V2[i], 0, 0, 0);
      chk("R9 V1 held during shift", drive_out, V1);
    end
    scan_en = 0; capture = 0; park = 0; launch = 1; #1;
    chk("R4 launch transparent", drive_out, V2);
    cyc("R9 launch", 0, 0, 0, 0, 1);
    chk("R9 V2 after launch", drive_out, V2);
    cyc("R6 capture", 0, 0, 1, 0, 0);
    for (int i = N - 1; i >= 0; i--) begin
      got[i] = scan_out;
      cyc("R6 unload", 1, 0, 0, 0, 0);
    end
    chk("R6 captured word", got, f(V2));
    chk("R3 drive after unload", drive_out, V2);

    shift_word("R2 shift 5A", 8'h5A, 1'b0);
    cyc("R8 shift+park", 1, 1, 0, 1, 0);
    cyc("R8 closed", 0, 0, 0, 0, 0);
    chk("R8 pre-shift word held", drive_out, 8'h5A);

    cyc("R7 shift+capture", 1, 0, 1, 0, 0);
    for (int i = 0; i < N; i++) cyc("R7 drain", 1, 0, 0, 0, 0);
    chk("R7 resp ignored", drive_out, 8'h5A);

    shift_word("R2 seed", 8'h01, 1'b0);
    for (int i = 0; i < 6; i++) cyc("R10 functional", 0, 0, 1, 0, 1);

    cyc("R3 idle", 0, 0, 0, 0, 0);
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule